// File: doc/BRIEF.md
# Voltage Code Decoder with Enable

This block sits between four external control pins and the controller of a step-down regulator. The four pins together carry a code. The all-zero code means shutdown. Each of the fifteen non-zero codes both enables the regulator and selects an output set point, so the regulator has no separate enable pin. The block synchronizes the pins into its own clock domain and registers an enable flag and a set-point value in millivolts. On every power-on it also gives the controller a single-cycle soft-start request.

The block also drives the enables of the weak pull-downs on the pins. A pin's pull-down holds the pin low until the pin is seen high. After that the pull-down stays released until all four pins read low at the same time, or until the supply flag drops. Because the enable comes from the code itself, a code change that passes through all-zero for even one sampled cycle shuts the regulator down and later starts it again.

All pins are plain level signals. No data flows through the block, so there is no valid/ready interface and no back-pressure.

Top module: `vcode_ctl`

## Requirements
- R1: While reset is asserted and right after it, `en_o` is 0, `setpoint_mv` is 0, `ss_start` is 0 and all four `pd_en` bits are 1.
- R2: A change on `ctl_pins` passes through a two-flop synchronizer plus one output register. It reaches the outputs on the third rising clock edge after the change and not before.
- R3: When the synchronized code is 4'b0000, `en_o` is 0 and `setpoint_mv` is 0.
- R4: When the synchronized code is non-zero, `en_o` is 1 and `setpoint_mv` takes the value for that code. Codes 1 to 15 map to 800, 1000, 1100, 1200, 1350, 1500, 1600, 1800, 2000, 2500, 2800, 3000, 3300, 3400 and 3600 mV.
- R5: `ss_start` is high for exactly one cycle: the first cycle in which `en_o` is 1 after having been 0.
- R6: A change from one non-zero code to another updates `setpoint_mv` with the normal latency and does not raise `ss_start`.
- R7: An all-zero code that lasts for a single sampled clock drops `en_o` for one cycle. When the code returns to non-zero, `ss_start` pulses again.
- R8: While `supply_ok` is 1, `pd_en[i]` goes to 0 on the same edge at which synchronized bit i is seen as 1.
- R9: A released pull-down stays released (`pd_en[i]` = 0) when its pin goes low again while any other pin is still high.
- R10: When the synchronized code is all-zero, all `pd_en` bits return to 1 on that edge.
- R11: On any edge at which `supply_ok` is 0, all `pd_en` bits become 1, whatever the pins read. The enable and set point still follow the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_pins | input | 4 | Raw control code from the pins, asynchronous |
| supply_ok | input | 1 | 1 when the supply is above the pull-down release level |
| en_o | output | 1 | Regulator enable |
| setpoint_mv | output | 12 | Selected output set point in millivolts, 0 in shutdown |
| pd_en | output | 4 | Per-pin weak pull-down enable, 1 = pull-down active |
| ss_start | output | 1 | One-cycle soft-start request at power-on |

## Verification
A stuck or stale release latch shows as a wrong `pd_en` bit within three clocks of the pin change that should have set or cleared it. An enable register that is out of step with the code shows either as a missing `ss_start` after a one-cycle zero glitch or as a spurious pulse on a plain set-point change. An error in the lookup shows at once as a wrong `setpoint_mv` value three clocks after the code is applied. The bench walks every code and tests each of these paths.

// File: rtl/vcode_pkg.sv
package vcode_pkg;
  localparam int CODE_W = 4;
  localparam int MV_W   = 12;

  // Set point in millivolts for each control code; code 0 is shutdown.
  function automatic logic [MV_W-1:0] code_to_mv(input logic [CODE_W-1:0] code);
    logic [MV_W-1:0] mv;
    case (code)
      4'd1:    mv = 12'd800;
      4'd2:    mv = 12'd1000;
      4'd3:    mv = 12'd1100;
      4'd4:    mv = 12'd1200;
      4'd5:    mv = 12'd1350;
      4'd6:    mv = 12'd1500;
      4'd7:    mv = 12'd1600;
      4'd8:    mv = 12'd1800;
      4'd9:    mv = 12'd2000;
      4'd10:   mv = 12'd2500;
      4'd11:   mv = 12'd2800;
      4'd12:   mv = 12'd3000;
      4'd13:   mv = 12'd3300;
      4'd14:   mv = 12'd3400;
      4'd15:   mv = 12'd3600;
      default: mv = '0;
    endcase
    return mv;
  endfunction
endpackage

// File: rtl/vcode_sync.sv
module vcode_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/vcode_pulldown.sv
module vcode_pulldown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_ok,
  input  logic [W-1:0] code_s,
  output logic [W-1:0] pd_en
);
  logic all_low;
  assign all_low = (code_s == '0);

  for (genvar p = 0; p < W; p++) begin : g_pin
    logic released;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   released <= 1'b0;
      else if (!supply_ok || all_low) released <= 1'b0;
      else if (code_s[p])           released <= 1'b1;
    end
    assign pd_en[p] = ~released;
  end
endmodule

// File: rtl/vcode_decode.sv
module vcode_decode
  import vcode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_s,
  output logic              en_o,
  output logic [MV_W-1:0]   setpoint_mv,
  output logic              ss_start
);
  logic active;
  assign active = |code_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o        <= 1'b0;
      setpoint_mv <= '0;
      ss_start    <= 1'b0;
    end else begin
      en_o        <= active;
      setpoint_mv <= code_to_mv(code_s);
      ss_start    <= active & ~en_o;
    end
  end
endmodule

// File: rtl/vcode_ctl.sv
module vcode_ctl
  import vcode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ctl_pins,
  input  logic              supply_ok,
  output logic              en_o,
  output logic [MV_W-1:0]   setpoint_mv,
  output logic [CODE_W-1:0] pd_en,
  output logic              ss_start
);
  logic [CODE_W-1:0] code_s;

  vcode_sync #(.W(CODE_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ctl_pins),
    .q_sync  (code_s)
  );

  vcode_pulldown #(.W(CODE_W)) pd_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .code_s    (code_s),
    .pd_en     (pd_en)
  );

  vcode_decode dec_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .code_s      (code_s),
    .en_o        (en_o),
    .setpoint_mv (setpoint_mv),
    .ss_start    (ss_start)
  );
endmodule

// File: rtl/vcode_ctl_chk.sv
module vcode_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        supply_ok,
  input logic        en_o,
  input logic [11:0] setpoint_mv,
  input logic [3:0]  pd_en,
  input logic        ss_start
);
  // R5
  ss_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start |-> (en_o && !$past(en_o)));
  // R5
  rise_has_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_o) |-> ss_start);
  // R6
  no_ss_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && $past(en_o)) |-> !ss_start);
  // R3
  off_zero_mv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> (setpoint_mv == 12'd0));
  // R4
  on_mv_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |-> (setpoint_mv >= 12'd800 && setpoint_mv <= 12'd3600));
  // R10
  off_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> (pd_en == 4'hF));
  // R8
  on_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && $past(supply_ok)) |-> (pd_en != 4'hF));
  // R11
  supply_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(supply_ok) |-> (pd_en == 4'hF));
endmodule

bind vcode_ctl vcode_ctl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_ok   (supply_ok),
  .en_o        (en_o),
  .setpoint_mv (setpoint_mv),
  .pd_en       (pd_en),
  .ss_start    (ss_start)
);

// File: tb/vcode_ctl_tb_top.sv
module vcode_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ctl_pins = 4'h0;
  logic        supply_ok = 1'b1;
  logic        en_o;
  logic [11:0] setpoint_mv;
  logic [3:0]  pd_en;
  logic        ss_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vcode_ctl dut_i (
    .clk (clk), .rst_n (rst_n), .ctl_pins (ctl_pins), .supply_ok (supply_ok),
    .en_o (en_o), .setpoint_mv (setpoint_mv), .pd_en (pd_en), .ss_start (ss_start)
  );

  function automatic int exp_mv(input int c);
    int t[16] = '{0, 800, 1000, 1100, 1200, 1350, 1500, 1600,
                  1800, 2000, 2500, 2800, 3000, 3300, 3400, 3600};
    return t[c];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, let three edges pass, end at the sampling negedge
  task automatic apply(input logic [3:0] c);
    @(negedge clk) ctl_pins = c;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(en_o == 1'b0, "R1 en", en_o, 0);
    chk(setpoint_mv == 12'd0, "R1 mv", setpoint_mv, 0);
    chk(ss_start == 1'b0, "R1 ss", ss_start, 0);
    chk(pd_en == 4'hF, "R1 pd", pd_en, 15);
  endtask

  task automatic t_latency();
    @(negedge clk) ctl_pins = 4'd8;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(en_o == 1'b0, "R2 not yet", en_o, 0);
    @(posedge clk); @(negedge clk);
    chk(en_o == 1'b1, "R2 en", en_o, 1);
    chk(setpoint_mv == 12'd1800, "R2 mv", setpoint_mv, 1800);
    chk(ss_start == 1'b1, "R5 pulse", ss_start, 1);
    @(negedge clk);
    chk(ss_start == 1'b0, "R5 single", ss_start, 0);
    apply(4'd0);
    chk(en_o == 1'b0, "R3 en", en_o, 0);
    chk(setpoint_mv == 12'd0, "R3 mv", setpoint_mv, 0);
  endtask

  task automatic t_all_codes();
    for (int c = 1; c < 16; c++) begin
      apply(c[3:0]);
      chk(en_o == 1'b1, "R4 en", en_o, 1);
      chk(int'(setpoint_mv) == exp_mv(c), "R4 mv", setpoint_mv, exp_mv(c));
      if (c > 1) chk(ss_start == 1'b0, "R6 no ss", ss_start, 0);
    end
    apply(4'd0);
  endtask

  task automatic t_glitch();
    apply(4'd5);
    @(negedge clk) ctl_pins = 4'd0;
    @(negedge clk) ctl_pins = 4'd6;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(en_o == 1'b0, "R7 drop", en_o, 0);
    chk(pd_en == 4'hF, "R10 glitch rearm", pd_en, 15);
    @(negedge clk);
    chk(en_o == 1'b1, "R7 back", en_o, 1);
    chk(ss_start == 1'b1, "R7 ss", ss_start, 1);
    chk(setpoint_mv == 12'd1500, "R7 mv", setpoint_mv, 1500);
    apply(4'd0);
  endtask

  task automatic t_pulldown();
    apply(4'b0001);
    chk(pd_en == 4'b1110, "R8 pin0", pd_en, 14);
    apply(4'b0011);
    chk(pd_en == 4'b1100, "R8 pin1", pd_en, 12);
    apply(4'b0010);
    chk(pd_en == 4'b1100, "R9 sticky", pd_en, 12);
    chk(setpoint_mv == 12'd1000, "R6 mv", setpoint_mv, 1000);
    apply(4'b0000);
    chk(pd_en == 4'hF, "R10 rearm", pd_en, 15);
  endtask

  task automatic t_supply();
    supply_ok = 1'b0;
    apply(4'hF);
    chk(pd_en == 4'hF, "R11 held", pd_en, 15);
    chk(setpoint_mv == 12'd3600, "R11 mv", setpoint_mv, 3600);
    supply_ok = 1'b1;
    @(negedge clk);
    chk(pd_en == 4'h0, "R8 release", pd_en, 0);
    apply(4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_all_codes();
    t_glitch();
    t_pulldown();
    t_supply();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule